// File: doc/BRIEF.md
# Rational 2/3 Clock-Enable Resampler

This block changes a stream's sample rate by two thirds without dividing the clock. Every register runs on a single system clock. Two rate enables are made from that clock. One pulses every second cycle and the other every third cycle. Each lower-rate stage advances only on its own enable.

Input samples are registered on the half-rate enable and then expanded to full rate by zero insertion. A four-tap FIR runs on every cycle and smooths the zero-stuffed stream. A decimating output register keeps one filtered sample on each third-rate enable and flags it with a one-cycle valid pulse. Both enables are also driven on output pins, so neighbouring logic can line up with the sample phases.

Top module: `mrc_resampler`

## Requirements
- R1: `ce_half_o` is high in cycle 0 after reset release and in every second cycle after that. It is high for one cycle each time.
- R2: `ce_third_o` is high in cycle 0 after reset release and in every third cycle after that. It is high for one cycle each time. Both enables are high together every 6 cycles.
- R3: `sample_i` is captured only in cycles where `ce_half_o` is high. The value on `sample_i` in any other cycle has no effect on `sample_o`.
- R4: The upsampled stream is zero in every cycle where `ce_half_o` is high. In the cycle after a capture it carries the captured sample. So u(c) = x(c-1) for odd c, and u(c) = 0 otherwise.
- R5: The FIR has the fixed coefficients 1, 3, 3, 1 and sums at full precision. It has one register stage. The filtered value in cycle c is y(c) = floor((u(c-1) + 3u(c-2) + 3u(c-3) + u(c-4)) / 2) as a signed value of IN_W+2 bits. u is taken as 0 before cycle 0.
- R6: `sample_o` loads y(c) at the end of each cycle c where `ce_third_o` is high. It holds its value in all other cycles.
- R7: `valid_o` is high for exactly one cycle, the cycle after each `ce_third_o` cycle, and low otherwise.
- R8: While `rst_ni` is low, `sample_o` and `valid_o` are 0, both enables are high, and the delay line and data registers are cleared.
- R9: For full-scale positive or negative input the result does not overflow. The accumulated sum always fits the output width after the 1-bit right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | IN_W | Signed input sample, read on half-rate enable |
| sample_o | output | IN_W+2 | Signed decimated filtered sample |
| valid_o | output | 1 | One-cycle pulse when `sample_o` updates |
| ce_half_o | output | 1 | Divide-by-2 rate enable |
| ce_third_o | output | 1 | Divide-by-3 rate enable |

## Verification
The two enable counters can slip against each other. When that happens, the pair of phases seen at the output changes: `valid_o` and `sample_o` update one or two cycles away from the expected slot. Every output check after the slip also fails, because the bench predicts the exact cycle. A wrong zero-insertion phase, a wrong tap weight or a stale delay-line entry shows on the very next `sample_o` update, which is at most three cycles later. Impulse and full-scale patterns expose each coefficient and the truncation edge. Input values that change on non-capture cycles expose a capture on the wrong enable.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int TAPS   = 4;
  localparam int COEF_W = 3;
  localparam int SHIFT  = 1;

  function automatic int coef_of(int k);
    case (k)
      0, 3:    return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/mrc_ce_div.sv
module mrc_ce_div #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = (cnt_q == '0);

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R1
      ce_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o |=> !ce_o);
    end
  endgenerate
endmodule

// File: rtl/mrc_upsampler.sv
module mrc_upsampler #(
  parameter int IN_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ce_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic signed [IN_W-1:0] up_o
);
  logic signed [IN_W-1:0] in_q;
  logic                   fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= ce_i;
      if (ce_i) in_q <= sample_i;
    end
  end

  // sample shows once, then zeros fill the remaining slots
  assign up_o = fresh_q ? in_q : '0;

  // R3
  hold_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(in_q));
  // R4
  zero_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |-> (up_o == '0));
endmodule

// File: rtl/mrc_fir.sv
module mrc_fir
  import mrc_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [IN_W-1:0]   x_i,
  output logic signed [IN_W+1:0]   y_o
);
  localparam int OUT_W = IN_W + 2;
  localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS);

  logic signed [IN_W-1:0]  dly_q [TAPS-1];
  logic signed [IN_W-1:0]  tap   [TAPS];
  logic signed [ACC_W-1:0] prod  [TAPS];
  logic signed [ACC_W-1:0] acc;

  assign tap[0] = x_i;

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam logic signed [ACC_W-1:0] C = ACC_W'(coef_of(k));
      if (k > 0) begin : g_link
        assign tap[k] = dly_q[k-1];
      end
      assign prod[k] = ACC_W'(tap[k]) * C;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS - 1; k++) dly_q[k] <= '0;
      y_o <= '0;
    end else begin
      dly_q[0] <= x_i;
      for (int k = 1; k < TAPS - 1; k++) dly_q[k] <= dly_q[k-1];
      y_o <= OUT_W'(acc >>> SHIFT);
    end
  end

  // R9
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc >= -(ACC_W'(1) <<< (OUT_W + SHIFT - 1))) &&
    (acc <   (ACC_W'(1) <<< (OUT_W + SHIFT - 1))));
endmodule

// File: rtl/mrc_decimator.sv
module mrc_decimator #(
  parameter int W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] sample_o,
  output logic                valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= ce_i;
      if (ce_i) sample_o <= y_i;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(sample_o));
  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/mrc_resampler.sv
module mrc_resampler #(
  parameter int IN_W        = 8,
  parameter int UP_FACTOR   = 2,
  parameter int DOWN_FACTOR = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] sample_i,
  output logic signed [IN_W+1:0] sample_o,
  output logic                   valid_o,
  output logic                   ce_half_o,
  output logic                   ce_third_o
);
  localparam int OUT_W = IN_W + 2;

  logic                   ce_up, ce_dn;
  logic signed [IN_W-1:0] up_s;
  logic signed [OUT_W-1:0] fir_y;

  mrc_ce_div #(.DIV(UP_FACTOR))   u_ce_up (.clk_i(clk_i), .rst_ni(rst_ni), .ce_o(ce_up));
  mrc_ce_div #(.DIV(DOWN_FACTOR)) u_ce_dn (.clk_i(clk_i), .rst_ni(rst_ni), .ce_o(ce_dn));

  mrc_upsampler #(.IN_W(IN_W)) u_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_up), .sample_i(sample_i), .up_o(up_s)
  );

  mrc_fir #(.IN_W(IN_W)) u_fir (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(up_s), .y_o(fir_y)
  );

  mrc_decimator #(.W(OUT_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_dn), .y_i(fir_y),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  assign ce_half_o  = ce_up;
  assign ce_third_o = ce_dn;

  generate
    if (UP_FACTOR == 2 && DOWN_FACTOR == 3) begin : g_align_chk
      // R2
      ce_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_up && ce_dn) |=> !(ce_up && ce_dn) ##1 !(ce_up && ce_dn)
          ##1 !(ce_up && ce_dn) ##1 !(ce_up && ce_dn) ##1 !(ce_up && ce_dn)
          ##1 (ce_up && ce_dn));
    end
  endgenerate
endmodule

// File: tb/mrc_resampler_tb.sv
module mrc_resampler_tb_top;
  localparam int IN_W = 8;
  localparam int NC   = 120;
  localparam int NP   = 6;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic signed [IN_W-1:0] sample_i = '0;
  logic signed [IN_W+1:0] sample_o;
  logic                   valid_o, ce_half_o, ce_third_o;

  int n_chk = 0;
  int n_bad = 0;
  int xs [NC];

  always #4 clk = ~clk;

  mrc_resampler #(.IN_W(IN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .sample_o(sample_o),
    .valid_o(valid_o), .ce_half_o(ce_half_o), .ce_third_o(ce_third_o)
  );

  function automatic int to_s8(int v);
    v = v & 255;
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int gen(int p, int c);
    case (p)
      0: return (c == 0) ? 64 : ((c % 2 == 1) ? to_s8(c * 29) : 0);
      1: return (c % 2 == 0) ? 127 : -100;
      2: return (c % 2 == 0) ? -128 : 77;
      3: return to_s8(c * 5 - 100);
      4: return to_s8((c * 73 + 41) ^ (c * c * 13));
      default: return (c % 2 == 1) ? 85 : (((c / 2) % 2 == 1) ? 127 : -128);
    endcase
  endfunction

  // R4 upsampled stream
  function automatic int up_m(int c);
    if (c < 1 || (c % 2) == 0) return 0;
    return xs[c-1];
  endfunction

  // R5 filtered value in cycle c
  function automatic int y_m(int c);
    int a;
    if (c < 1) return 0;
    a = up_m(c-1) + 3 * up_m(c-2) + 3 * up_m(c-3) + up_m(c-4);
    return a >>> 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200_000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hold;
    bit expv;
    repeat (3) @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < NC; c++) xs[c] = gen(p, c);
      @(negedge clk);
      rst_ni   = 1'b0;
      sample_i = 8'sd99;
      @(posedge clk);
      @(negedge clk);
      // R8 reset state
      chk("R8 sample_o", int'(sample_o), 0);
      chk("R8 valid_o", int'(valid_o), 0);
      chk("R8 ce_half_o", int'(ce_half_o), 1);
      chk("R8 ce_third_o", int'(ce_third_o), 1);
      rst_ni = 1'b1;
      hold = 0;
      for (int c = 0; c < NC; c++) begin
        if (c > 0) @(negedge clk);
        sample_i = IN_W'(xs[c]);
        #1;
        if (c >= 1 && ((c - 1) % 3) == 0) begin
          hold = y_m(c - 1);
          expv = 1'b1;
        end else begin
          expv = 1'b0;
        end
        chk("R1 ce_half_o", int'(ce_half_o), (c % 2 == 0) ? 1 : 0);
        chk("R2 ce_third_o", int'(ce_third_o), (c % 3 == 0) ? 1 : 0);
        chk("R7 valid_o", int'(valid_o), int'(expv));
        // R3 R4 R5 R6 R9: odd-cycle inputs must never reach sample_o
        chk("R6 sample_o", int'(sample_o), hold);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule